// File: doc/BRIEF.md
# Prescaled Modulus Timer Counter

This block is a 16-bit up-counter driven by a power-of-two prescaler. It is configured through a small register port. One control byte holds the overflow interrupt enable, the compare-reset enable and a 3-bit division select. A separate 16-bit compare word is the modulus value. When the compare-reset enable is clear, the counter runs through its whole range. On each wrap from all-ones to zero it raises a sticky overflow flag, which is cleared by writing one to it. When the compare-reset enable is set, a prescaled tick that finds the counter equal to the compare word loads zero in place of the increment. The counter then behaves as a modulus counter with period compare+1.

A new division select does not take effect at once. It is held until the free-running prescaler has returned to all zeros, so a period already in progress is never shortened or stretched. A global run input freezes both the prescaler and the counter.

Top module: `tmr_modcnt`

## Requirements
- R1: After reset, the control readback is 0x00, the counter is 0x0000, the overflow flag is 0 and the interrupt is 0.
- R2: Control readback returns bit 7 = interrupt enable, bit 3 = compare-reset enable, bits 2:0 = division select, exactly as last written. Bits 6:4 always read 0.
- R3: With run high and active select s, the counter advances by one every 2^s clock cycles, so codes 0..7 give divisors 1, 2, 4, ..., 128.
- R4: A written select becomes active only in a cycle where the 7-bit prescaler equals zero. Until then the previous divisor stays in force.
- R5: With compare-reset disabled, a tick at 0xFFFF moves the counter to 0x0000 and sets the overflow flag in the same clock edge.
- R6: With compare-reset enabled, a tick that finds the counter equal to the compare word loads 0x0000 instead of incrementing.
- R7: With compare-reset enabled and a compare word of 0x0000, a counter at 0x0000 stays at 0x0000 on every tick.
- R8: With compare-reset enabled and a compare word of 0xFFFF, the return from 0xFFFF to 0x0000 does not set the overflow flag.
- R9: While run is low, the counter and the prescaler hold their values.
- R10: The interrupt output is high exactly when the overflow flag is 1 and the interrupt enable is 1. The flag sets even when the enable is 0.
- R11: A pulse on the flag-clear input clears the overflow flag, but an overflow in the same cycle wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global count enable |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| cmp_wr | input | 1 | Compare word write strobe |
| cmp_wdata | input | 16 | Compare word write data |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| cnt_q | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench switches the divisor while the prescaler is part-way through a period. A design that applied the new select at once would advance the counter within a few cycles instead of holding it. The bench parks the compare word at 0x0000 and at 0xFFFF. Getting these wrong shows as a counter that creeps to 1 and back, or as a spurious overflow flag on the modulus wrap. It also pulses the flag clear in the very cycle of a wrap: a design with clear winning would leave the flag low. A freeze with run low checks that neither stage drifts while idle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTL_W     = 8;
   localparam int IE_POS    = 7;
   localparam int CRE_POS   = 3;
   localparam int SEL_MAX_W = 3;

   typedef logic [CTL_W-1:0] ctl_byte_t;

   // Mask of the implemented control bits for a given select width
   function automatic ctl_byte_t ctl_mask(input int sel_w);
      ctl_byte_t m;
      m = '0;
      m[IE_POS]  = 1'b1;
      m[CRE_POS] = 1'b1;
      for (int i = 0; i < sel_w; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SEL_W = 3,
   localparam int PRE_W = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [SEL_W-1:0] sel_req,
   output logic [SEL_W-1:0] act_sel,
   output logic             tick
);
   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] stage_mask;

   // Stage i takes part in the divide when the active select exceeds i
   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign stage_mask[i] = (int'(act_sel) > i);
   end

   assign tick = run_en && ((pre_cnt & stage_mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         act_sel <= '0;
      end else begin
         if (run_en) pre_cnt <= pre_cnt + 1'b1;
         // the new divisor is adopted only at the all-zero point
         if (pre_cnt == '0) act_sel <= sel_req;
      end
   end

   // R4: select changes only after a cycle with prescaler at zero
   p_sel_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_sel != $past(act_sel)) |-> ($past(pre_cnt) == '0));

   // R9: prescaler frozen while idle
   p_pre_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(pre_cnt));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cre,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_ev
);
   logic hit;

   assign hit     = cre && (cnt == cmp);
   assign wrap_ev = tick && !hit && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= hit ? '0 : cnt + 1'b1;
   end

   // R6: a successful compare loads zero on that tick
   p_mod_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cre && cnt == cmp) |=> (cnt == '0));

   // R3: an ordinary tick steps by exactly one
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(cre && cnt == cmp)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R9: no tick, no change
   p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   // R8: modulus wrap at all-ones never reports an overflow
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cre && (&cmp)) |-> !wrap_ev);
endmodule

// File: rtl/tmr_ovf.sv
module tmr_ovf #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr,
   input  logic ie,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set_ev) flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= flag && ie;
      end
   end else begin : g_irq_comb
      assign irq = flag && ie;
   end

   // R11: set has priority over a simultaneous clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag);

   // R11: a lone clear removes the flag
   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_ev) |=> !flag);

   // R5: flag is sticky until cleared
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/tmr_modcnt.sv
module tmr_modcnt
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SEL_W   = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_flag,
   output logic             irq
);
   localparam ctl_byte_t CTL_MASK = ctl_mask(SEL_W);

   if (SEL_W < 1 || SEL_W > SEL_MAX_W) begin : g_bad_sel
      $error("tmr_modcnt: SEL_W must lie in 1..%0d", SEL_MAX_W);
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_modcnt: CNT_W must be at least 2");
   end

   ctl_byte_t        ctl_q;
   logic [CNT_W-1:0] cmp_q;
   logic [SEL_W-1:0] act_sel;
   logic             tick;
   logic             wrap_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cmp_q <= '0;
      end else begin
         if (ctl_wr) ctl_q <= ctl_wdata & CTL_MASK;
         if (cmp_wr) cmp_q <= cmp_wdata;
      end
   end

   assign ctl_rdata = ctl_q;

   tmr_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .sel_req (ctl_q[SEL_W-1:0]),
      .act_sel (act_sel),
      .tick    (tick)
   );

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cre     (ctl_q[CRE_POS]),
      .cmp     (cmp_q),
      .cnt     (cnt_q),
      .wrap_ev (wrap_ev)
   );

   tmr_ovf #(.IRQ_REG(IRQ_REG)) u_ovf (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (wrap_ev),
      .clr    (ovf_clr),
      .ie     (ctl_q[IE_POS]),
      .flag   (ovf_flag),
      .irq    (irq)
   );

   // R2: unimplemented control bits never read as one
   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata & ~CTL_MASK) == '0);

   // R5: free-running wrap raises the flag on the next edge
   p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctl_q[CRE_POS] && (&cnt_q)) |=> (ovf_flag && cnt_q == '0));
endmodule

// File: tb/tmr_modcnt_test.sv
module tmr_modcnt_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 195000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  ctl_rdata;
   logic        cmp_wr = 1'b0;
   logic [15:0] cmp_wdata = '0;
   logic        ovf_clr = 1'b0;
   logic [15:0] cnt_q;
   logic        ovf_flag;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit live = 1'b0;
   string tag = "R1";

   // reference state
   int m_pre = 0, m_asel = 0, m_sel = 0, m_cnt = 0, m_cmp = 0;
   bit m_ie = 0, m_cre = 0, m_flag = 0;

   tmr_modcnt uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr),
      .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string t, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
      end
   endtask

   // behavioural model, updated on every edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_asel = 0; m_sel = 0; m_cnt = 0; m_cmp = 0;
         m_ie = 0; m_cre = 0; m_flag = 0;
      end else begin
         bit tk, hit, setv;
         int nasel;
         tk    = run_en && ((m_pre % (1 << m_asel)) == 0);
         hit   = m_cre && (m_cnt == m_cmp);
         setv  = 0;
         nasel = (m_pre == 0) ? m_sel : m_asel;
         if (run_en) m_pre = (m_pre + 1) % 128;
         if (tk) begin
            if (hit) m_cnt = 0;
            else if (m_cnt == 65535) begin m_cnt = 0; setv = 1; end
            else m_cnt = m_cnt + 1;
         end
         if (setv) m_flag = 1;
         else if (ovf_clr) m_flag = 0;
         m_asel = nasel;
         if (ctl_wr) begin
            m_ie = ctl_wdata[7]; m_cre = ctl_wdata[3]; m_sel = int'(ctl_wdata[2:0]);
         end
         if (cmp_wr) m_cmp = int'(cmp_wdata);
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (live) begin
         chk({tag, " cnt"}, int'(cnt_q), m_cnt);
         chk({tag, " flag"}, int'(ovf_flag), int'(m_flag));
         chk({tag, " irq"}, int'(irq), int'(m_flag && m_ie));
         chk({tag, " ctl"}, int'(ctl_rdata), (int'(m_ie) << 7) | (int'(m_cre) << 3) | m_sel);
      end
      if (cycles > WATCHDOG) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_cmp(input logic [15:0] d);
      cmp_wr = 1'b1; cmp_wdata = d;
      @(negedge clk);
      cmp_wr = 1'b0;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      while (cnt_q != v) @(negedge clk);
   endtask

   initial begin
      int saved;
      int top;
      step(3);
      rst_n = 1'b1;
      step(1);
      live = 1'b1;
      // R1 reset state
      chk("R1 ctl", int'(ctl_rdata), 0);
      chk("R1 cnt", int'(cnt_q), 0);
      chk("R1 flag", int'(ovf_flag), 0);
      chk("R1 irq", int'(irq), 0);

      // R2 readback with reserved bits forced low
      tag = "R2";
      wr_ctl(8'hFF);
      chk("R2 readback", int'(ctl_rdata), 8'h8F);
      wr_ctl(8'h40);
      chk("R2 reserved only", int'(ctl_rdata), 0);

      // R7 compare word zero with reset enabled
      tag = "R7";
      wr_cmp(16'h0000);
      wr_ctl(8'h08);
      run_en = 1'b1;
      step(60);
      chk("R7 held at zero", int'(cnt_q), 0);

      // R6 modulus of 21 at divide-by-2
      tag = "R6";
      wr_cmp(16'd20);
      wr_ctl(8'h09);
      top = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (int'(cnt_q) > top) top = int'(cnt_q);
      end
      chk("R6 peak equals compare", top, 20);

      // R9 freeze
      tag = "R9";
      run_en = 1'b0;
      step(1);
      saved = int'(cnt_q);
      step(25);
      chk("R9 frozen", int'(cnt_q), saved);
      run_en = 1'b1;

      // R3 every divisor, free running
      tag = "R3";
      for (int s = 0; s < 8; s++) begin
         wr_ctl(8'(s));
         step(300);
         chk($sformatf("R3 sel %0d", s), int'(cnt_q), m_cnt);
      end

      // R4 deferred divisor change (select 7 active now)
      tag = "R4";
      saved = int'(cnt_q);
      while (int'(cnt_q) == saved) @(negedge clk);
      saved = int'(cnt_q);
      wr_ctl(8'h00);
      step(5);
      chk("R4 old divisor kept", int'(cnt_q), saved);
      step(130);
      chk("R4 new divisor adopted", int'(cnt_q), m_cnt);

      // R5 and R11: wrap with a clear in the same cycle
      tag = "R5";
      wait_cnt(16'hFFFF);
      ovf_clr = 1'b1;
      step(1);
      ovf_clr = 1'b0;
      chk("R5 wrapped", int'(cnt_q), 0);
      chk("R11 set beats clear", int'(ovf_flag), 1);
      tag = "R10";
      chk("R10 no irq when disabled", int'(irq), 0);
      wr_ctl(8'h80);
      chk("R10 irq when enabled", int'(irq), 1);
      tag = "R11";
      ovf_clr = 1'b1;
      step(1);
      ovf_clr = 1'b0;
      chk("R11 cleared", int'(ovf_flag), 0);
      chk("R10 irq drops", int'(irq), 0);

      // R8 modulus wrap at all-ones
      tag = "R8";
      wr_cmp(16'hFFFF);
      wr_ctl(8'h88);
      wait_cnt(16'hFFFF);
      step(3);
      chk("R8 count after modulus wrap", int'(cnt_q), 2);
      chk("R8 no overflow", int'(ovf_flag), 0);
      chk("R8 no irq", int'(irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule